// File: doc/BRIEF.md
# Multi-Counter Event Monitor

This block gives a processor core a bank of event counters that software programs through a small synchronous register port. The core presents its activity as groups of 16 event lines. Each counter chooses one group and a 16-bit sub-event mask. It advances by one in any cycle where at least one selected line is active and the privilege filter lets that cycle through. A single global enable starts and stops every counter at once.

A counter can also act as the upper stage of its lower neighbour, counting that neighbour's wraps instead of core events. Each counter records a wrap in a sticky overflow flag that software clears by writing one to it. The flags of counters with their interrupt enable set are merged into one interrupt line. Software can load any counter with the negated sample period, so the interrupt fires after that many events.

Top module: `perf_monitor`

## Requirements
- R1: With the global enable set, a counter whose group select (control bits 12:8) is not 1 increments by exactly one in each cycle where the selected group's event vector ANDed with the mask (control bits 31:16) is nonzero. Group g occupies event input bits 16g+15 down to 16g. Counter i's value is at 0x1080+4i and its control is at 0x1100+4i.
- R2: While global enable (bit 0 of the register at 0x1000) is clear, no counter value changes unless software writes it.
- R3: A counter counts core events only when the privilege input is less than or equal to the trace-level field (control bits 7:4), or when the kernel-mode input is high and the kernel-count bit (control bit 3) is set.
- R4: The overflow flag (status bit 0, status at 0x1180+4i) becomes set in the cycle after an increment carries the counter from 0xFFFFFFFF to 0.
- R5: The overflow flag stays set through further wraps. Writing 1 to status bit 0 clears it, and writing 0 leaves it alone. When a clear and a new wrap land in the same cycle, the flag ends up set.
- R6: With group select 1, counter i adds one for each wrap of counter i-1, whatever its own mask and privilege filter say. Counter 0 with group select 1 never counts.
- R7: The interrupt output is high exactly when some counter has its overflow flag and its interrupt enable (control bit 0) both set. Status bit 4 reads that same condition for each counter.
- R8: A write to a value register loads the written data. The write takes priority over an increment in the same cycle, and that increment produces no overflow.
- R9: A control word of zero stops the counter. Control reads return only bits 0, 3, 7:4, 12:8 and 31:16, with every other bit reading zero. The global register reads zero in bits 31:1.
- R10: After reset, every register reads zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ev_in | input | 512 | 32 event groups of 16 lines each |
| priv_lvl | input | 4 | Current privilege level of the core |
| kern_mode | input | 1 | Core is running in kernel mode |
| irq | output | 1 | Merged overflow interrupt |

## Verification
A software clear of the overflow flag can arrive in the same cycle as a fresh wrap. The bench sets this up by preloading 0xFFFFFFFF into a counter that has already overflowed, then driving the status write and one qualifying event across the same clock edge. The flag and the interrupt must stay set, and a separate clear afterwards must drop both. A second same-cycle case is a value write against a qualifying event. There the written value must survive unchanged and no overflow may appear.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 16;
    localparam int EV_W        = 16;
    localparam int SEL_W       = 5;
    localparam int NUM_GROUPS  = 1 << SEL_W;
    localparam int CASCADE_SEL = 1;

    // register windows; 0x80 bytes each, 4-byte stride per counter
    localparam logic [ADDR_W-1:0] OFS_GLOBAL = 16'h1000;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 16'h1080;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 16'h1100;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 16'h1180;

    typedef enum logic [2:0] {
        RG_NONE, RG_GLOBAL, RG_VALUE, RG_CTRL, RG_STAT
    } region_e;

    typedef struct packed {
        logic [EV_W-1:0]  mask;
        logic [SEL_W-1:0] sel;
        logic [3:0]       trace;
        logic             kern;
        logic             ie;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.mask  = w[31:16];
        c.sel   = w[12:8];
        c.trace = w[7:4];
        c.kern  = w[3];
        c.ie    = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {c.mask, 3'b000, c.sel, c.trace, c.kern, 2'b00, c.ie};
    endfunction
endpackage

// File: rtl/pmu_addr_decode.sv
`timescale 1ns/1ps
module pmu_addr_decode
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [4:0]        idx
);
    always_comb begin
        idx    = addr[6:2];
        region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_GLOBAL)
                region = RG_GLOBAL;
            else if (32'(idx) < NUM_CNT) begin
                if (addr[ADDR_W-1:7] == OFS_VALUE[ADDR_W-1:7])      region = RG_VALUE;
                else if (addr[ADDR_W-1:7] == OFS_CTRL[ADDR_W-1:7])  region = RG_CTRL;
                else if (addr[ADDR_W-1:7] == OFS_STAT[ADDR_W-1:7])  region = RG_STAT;
            end
        end
    end
endmodule

// File: rtl/pmu_event_qual.sv
`timescale 1ns/1ps
module pmu_event_qual
    import pmu_pkg::*;
(
    input  logic [NUM_GROUPS*EV_W-1:0] ev_all,
    input  ctrl_t                      ctrl,
    input  logic [3:0]                 priv_lvl,
    input  logic                       kern_mode,
    output logic                       hit
);
    logic [EV_W-1:0] grp;
    logic            priv_ok;

    always_comb begin
        grp     = ev_all[ctrl.sel*EV_W +: EV_W];
        priv_ok = (priv_lvl <= ctrl.trace) || (kern_mode && ctrl.kern);
        hit     = priv_ok && (|(grp & ctrl.mask));
    end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              core_hit,
    input  logic              casc_in,
    input  logic              wr_val,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output ctrl_t             ctrl,
    output logic              ovf,
    output logic              wrap
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
        ctrl_t             ctrl;
        logic              ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       inc;

    always_comb begin
        st_d = st_q;
        inc  = run && ((st_q.ctrl.sel == SEL_W'(CASCADE_SEL)) ? casc_in : core_hit);
        wrap = inc && !wr_val && (&st_q.value);
        if (wr_val)
            st_d.value = wdata;
        else if (inc)
            st_d.value = st_q.value + 1'b1;
        if (wr_ctrl)
            st_d.ctrl = ctrl_from_word(wdata);
        // a new wrap outranks a same-cycle clear
        st_d.ovf = wrap | (st_q.ovf & ~(wr_stat & wdata[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;
    assign ctrl  = st_q.ctrl;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/perf_monitor.sv
`timescale 1ns/1ps
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_GROUPS*EV_W-1:0] ev_in,
    input  logic [3:0]                 priv_lvl,
    input  logic                       kern_mode,
    output logic                       irq
);
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    typedef struct packed {
        logic en;
    } glb_t;

    glb_t    glb_d, glb_q;
    region_e region;
    logic [4:0] idx;
    logic    wr;
    logic    glb_en;

    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val;
    ctrl_t [NUM_CNT-1:0]            cnt_ctrl;
    logic [NUM_CNT-1:0] ovf_vec, ie_vec, wrap_vec, hit_vec;
    logic [NUM_CNT-1:0] val_wr, ctrl_wr, stat_wr, sts_clr;

    pmu_addr_decode #(.NUM_CNT(NUM_CNT)) u_dec (
        .addr(bus_addr), .region(region), .idx(idx)
    );

    assign wr     = bus_sel && bus_we;
    assign glb_en = glb_q.en;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic casc;
        if (i == 0) begin : g_first
            assign casc = 1'b0;
        end else begin : g_chain
            assign casc = wrap_vec[i-1];
        end

        assign val_wr[i]  = wr && (region == RG_VALUE) && (idx == 5'(i));
        assign ctrl_wr[i] = wr && (region == RG_CTRL)  && (idx == 5'(i));
        assign stat_wr[i] = wr && (region == RG_STAT)  && (idx == 5'(i));
        assign sts_clr[i] = stat_wr[i] && bus_wdata[0];

        pmu_event_qual u_qual (
            .ev_all(ev_in), .ctrl(cnt_ctrl[i]), .priv_lvl(priv_lvl),
            .kern_mode(kern_mode), .hit(hit_vec[i])
        );

        pmu_counter u_cnt (
            .clk(clk), .rst_n(rst_n), .run(glb_q.en), .core_hit(hit_vec[i]),
            .casc_in(casc), .wr_val(val_wr[i]), .wr_ctrl(ctrl_wr[i]),
            .wr_stat(stat_wr[i]), .wdata(bus_wdata), .value(cnt_val[i]),
            .ctrl(cnt_ctrl[i]), .ovf(ovf_vec[i]), .wrap(wrap_vec[i])
        );

        assign ie_vec[i] = cnt_ctrl[i].ie;
    end

    always_comb begin
        glb_d = glb_q;
        if (wr && region == RG_GLOBAL)
            glb_d.en = bus_wdata[0];

        bus_rdata = '0;
        case (region)
            RG_GLOBAL: bus_rdata = {{(DATA_W-1){1'b0}}, glb_q.en};
            RG_VALUE:  bus_rdata = cnt_val[idx[IDX_W-1:0]];
            RG_CTRL:   bus_rdata = ctrl_to_word(cnt_ctrl[idx[IDX_W-1:0]]);
            RG_STAT:   bus_rdata = {27'd0,
                                    ovf_vec[idx[IDX_W-1:0]] & ie_vec[idx[IDX_W-1:0]],
                                    3'd0, ovf_vec[idx[IDX_W-1:0]]};
            default:   bus_rdata = '0;
        endcase

        irq = |(ovf_vec & ie_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= glb_d;
    end
endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
    parameter int NUM_CNT = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     glb_en,
    input logic [NUM_CNT-1:0]       val_wr,
    input logic [NUM_CNT-1:0]       sts_clr,
    input logic [NUM_CNT-1:0][31:0] cnt_val,
    input logic [NUM_CNT-1:0]       ovf,
    input logic [NUM_CNT-1:0]       ie,
    input logic                     irq
);
    assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && val_wr == '0) |=> $stable(cnt_val));

    assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ovf));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !val_wr[i] |=> (cnt_val[i] == $past(cnt_val[i]) ||
                            cnt_val[i] == $past(cnt_val[i]) + 32'd1));

        assert_ovf_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf[i]) |-> ($past(cnt_val[i]) == 32'hFFFF_FFFF && cnt_val[i] == 32'd0));

        assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && !sts_clr[i]) |=> ovf[i]);

        assert_no_irq_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '0) |-> !irq);
    end
endmodule

bind perf_monitor pmu_checker #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .val_wr(val_wr),
    .sts_clr(sts_clr), .cnt_val(cnt_val), .ovf(ovf_vec), .ie(ie_vec), .irq(irq)
);

// File: tb/sim_perf_monitor.sv
`timescale 1ns/1ps
module sim_perf_monitor;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [511:0] ev = '0;
    logic [3:0]   priv_lvl = '0;
    logic         kern_mode = 1'b0;
    logic         irq;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    perf_monitor u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_in(ev), .priv_lvl(priv_lvl), .kern_mode(kern_mode), .irq(irq)
    );

    function automatic logic [31:0] mk_ctrl(input logic [15:0] mask, input logic [4:0] sel,
                                            input logic [3:0] trace, input logic kern,
                                            input logic ie);
        return {mask, 3'b000, sel, trace, kern, 2'b00, ie};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev = '0; priv_lvl = '0; kern_mode = 1'b0;
        bus_sel = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int g, input logic [15:0] v, input int n);
        @(negedge clk);
        ev = '0;
        ev[g*16 +: 16] = v;
        repeat (n) @(negedge clk);
        ev = '0;
    endtask

    function automatic logic [15:0] val_a(input int i);  return 16'h1080 + 16'(4*i); endfunction
    function automatic logic [15:0] ctl_a(input int i);  return 16'h1100 + 16'(4*i); endfunction
    function automatic logic [15:0] sts_a(input int i);  return 16'h1180 + 16'(4*i); endfunction

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(16'h1000, d); check("R10 global", d, 0);
        rd(val_a(3), d); check("R10 value", d, 0);
        rd(ctl_a(0), d); check("R10 ctrl", d, 0);
        rd(sts_a(7), d); check("R10 status", d, 0);
        check("R10 irq", 32'(irq), 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(0), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b0));
        wr(ctl_a(1), mk_ctrl(16'hFFFF, 5'd2, 4'hF, 1'b0, 1'b0));
        wr(16'h1000, 32'd1);
        pulse(0, 16'h0001, 5);
        rd(val_a(0), d); check("R1 masked group0 count", d, 5);
        pulse(0, 16'h0002, 4);
        rd(val_a(0), d); check("R1 line outside mask", d, 5);
        pulse(2, 16'h8000, 3);
        rd(val_a(1), d); check("R1 group2 full mask", d, 3);
        rd(val_a(0), d); check("R1 other group untouched", d, 5);
    endtask

    task automatic t_global_off();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(2), mk_ctrl(16'hFFFF, 5'd4, 4'hF, 1'b0, 1'b0));
        pulse(4, 16'hFFFF, 6);
        rd(val_a(2), d); check("R2 off from reset", d, 0);
        wr(16'h1000, 32'd1);
        pulse(4, 16'h0100, 2);
        wr(16'h1000, 32'd0);
        pulse(4, 16'hFFFF, 6);
        rd(val_a(2), d); check("R2 off after running", d, 2);
    endtask

    task automatic t_priv();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(0), mk_ctrl(16'h0001, 5'd0, 4'd2, 1'b0, 1'b0));
        wr(16'h1000, 32'd1);
        priv_lvl = 4'd3; kern_mode = 1'b1;
        pulse(0, 16'h0001, 4);
        rd(val_a(0), d); check("R3 level above trace, kern bit clear", d, 0);
        wr(ctl_a(0), mk_ctrl(16'h0001, 5'd0, 4'd2, 1'b1, 1'b0));
        pulse(0, 16'h0001, 3);
        rd(val_a(0), d); check("R3 kernel override", d, 3);
        kern_mode = 1'b0;
        pulse(0, 16'h0001, 3);
        rd(val_a(0), d); check("R3 blocked without kernel mode", d, 3);
        priv_lvl = 4'd2;
        pulse(0, 16'h0001, 2);
        rd(val_a(0), d); check("R3 level equal to trace", d, 5);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(5), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b1));
        wr(val_a(5), 32'hFFFF_FFFE);
        wr(16'h1000, 32'd1);
        pulse(0, 16'h0001, 1);
        rd(sts_a(5), d); check("R4 no flag before wrap", d, 0);
        check("R7 irq low before wrap", 32'(irq), 0);
        pulse(0, 16'h0001, 1);
        rd(val_a(5), d); check("R4 wrapped to zero", d, 0);
        rd(sts_a(5), d); check("R4 R7 flag and irq bit", d, 32'h11);
        check("R7 irq high", 32'(irq), 1);
        pulse(0, 16'h0001, 3);
        rd(sts_a(5), d); check("R5 sticky", d, 32'h11);
        wr(sts_a(5), 32'h0);
        rd(sts_a(5), d); check("R5 zero write ignored", d, 32'h11);
        wr(ctl_a(5), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b0));
        rd(sts_a(5), d); check("R7 masked status bit4", d, 32'h01);
        check("R7 irq gated by enable", 32'(irq), 0);
        wr(sts_a(5), 32'h1);
        rd(sts_a(5), d); check("R5 one clears", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(0), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b1));
        wr(val_a(0), 32'hFFFF_FFFF);
        wr(16'h1000, 32'd1);
        pulse(0, 16'h0001, 1);
        wr(val_a(0), 32'hFFFF_FFFF);
        @(negedge clk);
        ev[15:0] = 16'h0001;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = sts_a(0); bus_wdata = 32'h1;
        @(negedge clk);
        ev = '0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(sts_a(0), d); check("R5 wrap beats clear", d, 32'h11);
        check("R5 irq kept", 32'(irq), 1);
        wr(sts_a(0), 32'h1);
        rd(sts_a(0), d); check("R5 clear alone", d, 0);
        check("R7 irq dropped", 32'(irq), 0);
    endtask

    task automatic t_cascade();
        logic [31:0] d;
        do_reset();
        priv_lvl = 4'hF;
        wr(ctl_a(0), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b0));
        wr(ctl_a(1), mk_ctrl(16'h0000, 5'd1, 4'h0, 1'b0, 1'b0));
        wr(val_a(0), 32'hFFFF_FFFE);
        wr(16'h1000, 32'd1);
        pulse(0, 16'h0001, 3);
        rd(val_a(0), d); check("R6 low stage", d, 1);
        rd(val_a(1), d); check("R6 upper stage one wrap", d, 1);
        pulse(1, 16'hFFFF, 4);
        rd(val_a(1), d); check("R6 group1 lines unused", d, 1);
        wr(ctl_a(0), mk_ctrl(16'hFFFF, 5'd1, 4'hF, 1'b0, 1'b0));
        @(negedge clk); ev = '1;
        repeat (4) @(negedge clk);
        ev = '0;
        rd(val_a(0), d); check("R6 counter0 cascade idle", d, 1);
    endtask

    task automatic t_write_prio();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(3), mk_ctrl(16'h0001, 5'd0, 4'hF, 1'b0, 1'b1));
        wr(16'h1000, 32'd1);
        @(negedge clk);
        ev[15:0] = 16'h0001;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = val_a(3); bus_wdata = 32'h100;
        @(negedge clk);
        ev = '0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(val_a(3), d); check("R8 write wins", d, 32'h100);
        wr(val_a(3), 32'hFFFF_FFFF);
        @(negedge clk);
        ev[15:0] = 16'h0001;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = val_a(3); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        ev = '0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(sts_a(3), d); check("R8 no overflow on write cycle", d, 0);
        rd(val_a(3), d); check("R8 value held", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        do_reset();
        wr(ctl_a(4), 32'hFFFF_FFFF);
        rd(ctl_a(4), d); check("R9 control readback", d, 32'hFFFF_1FF9);
        wr(16'h1000, 32'hFFFF_FFFF);
        rd(16'h1000, d); check("R9 global readback", d, 1);
        wr(ctl_a(4), 32'h0);
        @(negedge clk); ev = '1;
        repeat (5) @(negedge clk);
        ev = '0;
        rd(val_a(4), d); check("R9 zero control stops", d, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_global_off();
        t_priv();
        t_overflow();
        t_race();
        t_cascade();
        t_write_prio();
        t_ctrl();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule